// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a simple host request port and a 72-bit hyper-page (EDO) DRAM array. It turns each host request into the row strobe, column strobe, write-enable, output-enable and multiplexed address waveforms that the array needs. Every request carries a 23-bit word address: the upper 12 bits select the row and the lower 11 bits select the column. The block runs from one system clock. Each DRAM timing limit is a cycle-count parameter, so one design serves any clock rate.

After an access the row stays open. A later request to the same row costs only a column strobe. A request to another row, or a pending refresh, closes the page: the row strobe rises and the precharge time runs before the next row cycle starts. Refresh uses the column-before-row strobe order and needs no address. A refresh already pending takes priority over any new host request.

States: `ST_IDLE` (precharged, no row open), `ST_RCD` (row strobe low with the row address), `ST_COL` (column address and write level set up, column strobe high), `ST_CAS` (column strobe low), `ST_PAGE` (row held open, waiting), `ST_PRE` (precharge), `ST_CBR_CAS` (refresh: column strobe low first), `ST_CBR_RAS` (refresh: both strobes low).

Transitions:
- IDLE→CBR_CAS when a refresh is pending.
- IDLE→RCD on a request.
- RCD→COL when the row-to-column delay has elapsed.
- COL→CAS always.
- CAS→PAGE when the column time, and for reads the row access time, have been met. The ack pulse is issued here.
- PAGE→COL on a request to the same row.
- PAGE→PRE on a refresh or a row miss, once the minimum row-active time is met.
- PRE→IDLE after the precharge time.
- CBR_CAS→CBR_RAS always.
- CBR_RAS→PRE after the minimum row-active time.

Top module: `edo_page_sequencer`

## Requirements
- R1: While reset is held, all four strobes are high (inactive), `req_ack` and `rd_valid` are 0, and `dram_dq_oe` is 0.
- R2: When the row strobe falls for an access, `dram_addr` equals `req_addr[22:11]`. When the column strobe falls, `dram_addr[10:0]` equals `req_addr[10:0]` and `dram_addr[11]` is 0.
- R3: During a read, `dram_we_n` is high and `dram_oe_n` is low while the column strobe is low. `rd_data` returns the DQ input word for that address, with a one-cycle `rd_valid` that coincides with `req_ack`.
- R4: During an early write, `dram_we_n` goes low at least one cycle before the column strobe falls. `dram_oe_n` stays high, and `dram_dq_oe` is 1 with the write word on `dram_dq_out`.
- R5: A request whose row equals the open row completes without a new row-strobe fall.
- R6: A request to another row closes the page. The row strobe stays high for at least `T_RP` cycles before it falls again.
- R7: Every low period of the row strobe lasts at least `T_RAS` cycles.
- R8: For an access, the column strobe falls at least `T_RCD` cycles after the row strobe fell.
- R9: Read data is captured at least `T_CAS` cycles after the column strobe fell and at least `T_RAC` cycles after the row strobe fell.
- R10: A refresh pulls the column strobe low at least one cycle before the row strobe falls, keeps `dram_we_n` high, and produces no `req_ack`.
- R11: A refresh pending at the same time as a host request is serviced first. It closes the open page, so the request then reopens the row.
- R12: Each request gets exactly one single-cycle `req_ack`. A request still asserted in its ack cycle is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address: row in [22:11], column in [10:0] |
| req_wdata | input | 72 | Write word |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 72 | Read word, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| refresh_req | input | 1 | Pulse requesting one refresh cycle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 72 | Write data toward the array |
| dram_dq_oe | output | 1 | Drive enable for the write data |
| dram_dq_in | input | 72 | Data returned by the array |

## Verification
The bench builds the block with T_RAS=8, T_RP=3, T_RCD=2, T_CAS=2 and T_RAC=6. With these values a read that opens a fresh row is limited by the row access time, because the row delay, the column setup cycle and the column time add up to only five cycles. The column strobe must therefore stretch. Page-hit reads, by contrast, are limited only by the column time. The row-active minimum is longer than a single access, so a row miss or a refresh right after an access has to wait in the open-page state before precharging, and that closing path is exercised as well.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_PAGE,
        ST_PRE,
        ST_CBR_CAS,
        ST_CBR_RAS
    } seq_state_t;

    // States in which the row strobe is held low
    function automatic logic row_strobe_low(seq_state_t s);
        return (s == ST_RCD) || (s == ST_COL) || (s == ST_CAS) ||
               (s == ST_PAGE) || (s == ST_CBR_RAS);
    endfunction

endpackage

// File: rtl/edo_wait_timer.sv
module edo_wait_timer #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_refresh_pending.sv
module edo_refresh_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_req,
    input  logic take,
    output logic pending
);
    logic flag;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= (flag | refresh_req) & ~take;
    end

    // A request arriving this cycle already counts as pending
    assign pending = flag | refresh_req;
endmodule

// File: rtl/edo_page_sequencer.sv
module edo_page_sequencer
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 11,
    parameter int DATA_W = 72,
    parameter int T_RAS  = 13,
    parameter int T_RP   = 8,
    parameter int T_RCD  = 4,
    parameter int T_CAS  = 4,
    parameter int T_RAC  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ack,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid,
    input  logic                    refresh_req,
    output logic                    dram_ras_n,
    output logic                    dram_cas_n,
    output logic                    dram_we_n,
    output logic                    dram_oe_n,
    output logic [ROW_W-1:0]        dram_addr,
    output logic [DATA_W-1:0]       dram_dq_out,
    output logic                    dram_dq_oe,
    input  logic [DATA_W-1:0]       dram_dq_in
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int T_MAX0  = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int T_MAX1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX   = (T_MAX0 > T_MAX1) ? T_MAX0 : T_MAX1;
    localparam int TMR_W   = $clog2(T_MAX + 1);
    localparam int AGE_A   = (T_RAS > T_RAC) ? T_RAS : T_RAC;
    localparam int AGE_LIM = (AGE_A > T_RCD + 1) ? AGE_A : T_RCD + 1;
    localparam int AGE_W   = $clog2(AGE_LIM + 1);
    localparam int PRE_W   = $clog2(T_RP + 1);

    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(AGE_LIM);
    localparam logic [AGE_W-1:0] RAS_MIN  = AGE_W'(T_RAS);
    localparam logic [AGE_W-1:0] RAC_MIN  = AGE_W'(T_RAC);
    localparam logic [AGE_W-1:0] RCD_MIN  = AGE_W'(T_RCD + 1);
    localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(T_RP);
    localparam logic [TMR_W-1:0] LD_RCD   = TMR_W'(T_RCD - 1);
    localparam logic [TMR_W-1:0] LD_CAS   = TMR_W'(T_CAS - 1);
    localparam logic [TMR_W-1:0] LD_RAS   = TMR_W'(T_RAS - 1);
    localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(T_RP - 1);

    seq_state_t state, state_n;

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [AGE_W-1:0]  ras_age;
    logic [PRE_W-1:0]  pre_age;
    logic              ack_q, rdv_q;
    logic [DATA_W-1:0] rdata_q;

    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              ref_pend, ref_take;
    logic              accept, finish;
    logic [ROW_W-1:0]  req_row;

    assign req_row = req_addr[ADDR_W-1:COL_W];

    edo_wait_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_refresh_pending u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_req (refresh_req),
        .take        (ref_take),
        .pending     (ref_pend)
    );

    // Next-state logic
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_take = 1'b0;
        accept   = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_take = 1'b1;
                    state_n  = ST_CBR_CAS;
                end else if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RCD;
                    state_n  = ST_RCD;
                end
            end
            ST_RCD: if (tmr_done) state_n = ST_COL;
            ST_COL: begin
                tmr_load = 1'b1;
                tmr_val  = LD_CAS;
                state_n  = ST_CAS;
            end
            ST_CAS: begin
                if (tmr_done && (wr_q || ras_age >= RAC_MIN)) begin
                    finish  = 1'b1;
                    state_n = ST_PAGE;
                end
            end
            ST_PAGE: begin
                if (!ack_q) begin
                    if (ref_pend || (req_valid && req_row != row_q)) begin
                        if (ras_age >= RAS_MIN) begin
                            tmr_load = 1'b1;
                            tmr_val  = LD_RP;
                            state_n  = ST_PRE;
                        end
                    end else if (req_valid) begin
                        accept  = 1'b1;
                        state_n = ST_COL;
                    end
                end
            end
            ST_PRE: if (tmr_done) state_n = ST_IDLE;
            ST_CBR_CAS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RAS;
                state_n  = ST_CBR_RAS;
            end
            ST_CBR_RAS: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_RP;
                    state_n  = ST_PRE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Request latch, strobe age counters, response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            ras_age <= '0;
            pre_age <= PRE_MAX;
            ack_q   <= 1'b0;
            rdv_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                row_q   <= req_row;
                col_q   <= req_addr[COL_W-1:0];
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            if (!row_strobe_low(state_n))
                ras_age <= '0;
            else if (!row_strobe_low(state))
                ras_age <= AGE_W'(1);
            else if (ras_age != AGE_MAX)
                ras_age <= ras_age + 1'b1;
            if (row_strobe_low(state_n))
                pre_age <= '0;
            else if (row_strobe_low(state))
                pre_age <= PRE_W'(1);
            else if (pre_age != PRE_MAX)
                pre_age <= pre_age + 1'b1;
            ack_q <= finish;
            rdv_q <= finish & ~wr_q;
            if (finish && !wr_q)
                rdata_q <= dram_dq_in;
        end
    end

    // Output decode
    always_comb begin
        dram_ras_n  = ~row_strobe_low(state);
        dram_cas_n  = ~((state == ST_CAS) || (state == ST_CBR_CAS) || (state == ST_CBR_RAS));
        dram_we_n   = ~(wr_q && ((state == ST_COL) || (state == ST_CAS)));
        dram_oe_n   = ~(!wr_q && (state == ST_CAS));
        dram_dq_oe  = wr_q && ((state == ST_COL) || (state == ST_CAS));
        dram_dq_out = wdata_q;
        unique case (state)
            ST_RCD:         dram_addr = row_q;
            ST_COL, ST_CAS: dram_addr = {{(ROW_W-COL_W){1'b0}}, col_q};
            default:        dram_addr = '0;
        endcase
        req_ack  = ack_q;
        rd_valid = rdv_q;
        rd_data  = rdata_q;
    end

    // Protocol checks
    assert_ras_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> $past(ras_age) >= RAS_MIN);

    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(pre_age) >= PRE_MAX);

    assert_rcd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> ras_age >= RCD_MIN);

    assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ras_age) >= RAC_MIN);

    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_rdvalid_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> req_ack);
endmodule

// File: tb/tb_edo_page_sequencer.sv
`timescale 1ns/1ps
module tb_edo_page_sequencer;
    localparam int T_RAS = 8, T_RP = 3, T_RCD = 2, T_CAS = 2, T_RAC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
    logic [22:0] req_addr = '0;
    logic [71:0] req_wdata = '0;
    logic        req_ack, rd_valid;
    logic [71:0] rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;
    logic [71:0] dram_dq_out;
    logic [71:0] dram_dq_in = '0;

    int checks = 0, errors = 0, cyc = 0;
    int acks = 0, ops = 0, ras_falls = 0, refresh_cnt = 0;
    int ras_fall_cyc = 0, ras_low_start = 0, ras_rise_cyc = -1000, cas_fall_cyc = 0;
    int last_ref_cyc = 0, ack_cyc = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_ack = 1'b0;
    logic [11:0] row_l = '0;
    logic [22:0] cur_addr = '0;
    logic [71:0] exp_q[$];
    logic [71:0] shadow[logic [22:0]];
    logic [71:0] dmem[logic [22:0]];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edo_page_sequencer #(
        .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAC(T_RAC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .refresh_req(refresh_req),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    function automatic logic [71:0] pat(input logic [22:0] a);
        return {~a, a, a, 3'b101};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issues one request, pushes the expected read word to the scoreboard
    task automatic host_op(input bit wr, input logic [22:0] a, input logic [71:0] d, input bit with_refresh);
        @(posedge clk); #1;
        cur_addr    = a;
        req_valid   = 1'b1;
        req_write   = wr;
        req_addr    = a;
        req_wdata   = d;
        refresh_req = with_refresh;
        ops++;
        if (wr) shadow[a] = d;
        else exp_q.push_back(shadow.exists(a) ? shadow[a] : pat(a));
        @(posedge clk); #1;
        refresh_req = 1'b0;
        forever begin
            @(negedge clk);
            if (req_ack) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: DRAM array model, timing measurement and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ack) begin
                acks++;
                ack_cyc = cyc;
                chk(!prev_ack, "R12 ack single cycle", 72'(prev_ack), 72'd0);
            end
            if (rd_valid) begin
                chk(req_ack, "R3 rd_valid with ack", 72'(req_ack), 72'd1);
                if (exp_q.size() == 0)
                    chk(1'b0, "R3 unexpected rd_valid", rd_data, 72'd0);
                else begin
                    logic [71:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3 read data", rd_data, e);
                end
                chk(cyc - cas_fall_cyc >= T_CAS, "R9 capture after CAS", 72'(cyc - cas_fall_cyc), 72'(T_CAS));
                chk(cyc - ras_fall_cyc >= T_RAC, "R9 capture after RAS", 72'(cyc - ras_fall_cyc), 72'(T_RAC));
            end
            if (prev_ras && !dram_ras_n) begin
                ras_low_start = cyc;
                if (!dram_cas_n) begin
                    refresh_cnt++;
                    last_ref_cyc = cyc;
                    chk(!prev_cas, "R10 CAS before RAS", 72'(prev_cas), 72'd0);
                    chk(dram_we_n, "R10 we high in refresh", 72'(dram_we_n), 72'd1);
                end else begin
                    ras_falls++;
                    ras_fall_cyc = cyc;
                    row_l = dram_addr;
                    chk(cyc - ras_rise_cyc >= T_RP, "R6 precharge time", 72'(cyc - ras_rise_cyc), 72'(T_RP));
                    chk(dram_addr == cur_addr[22:11], "R2 row address", 72'(dram_addr), 72'(cur_addr[22:11]));
                end
            end
            if (!prev_ras && dram_ras_n) begin
                ras_rise_cyc = cyc;
                chk(cyc - ras_low_start >= T_RAS, "R7 RAS active time", 72'(cyc - ras_low_start), 72'(T_RAS));
            end
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                logic [22:0] key;
                cas_fall_cyc = cyc;
                key = {row_l, dram_addr[10:0]};
                chk(cyc - ras_fall_cyc >= T_RCD, "R8 RAS to CAS delay", 72'(cyc - ras_fall_cyc), 72'(T_RCD));
                chk(dram_addr == {1'b0, cur_addr[10:0]}, "R2 column address", 72'(dram_addr), 72'({1'b0, cur_addr[10:0]}));
                if (!dram_we_n) begin
                    chk(!prev_we, "R4 we before CAS", 72'(prev_we), 72'd0);
                    chk(dram_dq_oe && dram_oe_n, "R4 drive on, oe off", 72'({dram_dq_oe, dram_oe_n}), 72'd3);
                    chk(dram_dq_out == req_wdata, "R4 write word", dram_dq_out, req_wdata);
                    dmem[key] = dram_dq_out;
                end else begin
                    chk(!dram_oe_n, "R3 oe low on read", 72'(dram_oe_n), 72'd0);
                    dram_dq_in = dmem.exists(key) ? dmem[key] : pat(key);
                end
            end
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
        prev_we  = dram_we_n;
        prev_ack = req_ack;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rs0, rf0, ak0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes idle",
            72'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 72'hF);
        chk({req_ack, rd_valid, dram_dq_oe} == 3'b000, "R1 outputs quiet",
            72'({req_ack, rd_valid, dram_dq_oe}), 72'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        host_op(1'b1, {12'h005, 11'h003}, 72'hA5_0123_4567_89AB_CDEF, 1'b0);
        rs0 = ras_falls;
        host_op(1'b0, {12'h005, 11'h003}, '0, 1'b0);
        host_op(1'b1, {12'h005, 11'h7FF}, 72'h3C_FFFF_0000_1234_5678, 1'b0);
        host_op(1'b0, {12'h005, 11'h7FF}, '0, 1'b0);
        chk(ras_falls == rs0, "R5 page hit keeps row", 72'(ras_falls), 72'(rs0));

        rs0 = ras_falls;
        host_op(1'b0, {12'hABC, 11'h155}, '0, 1'b0);
        chk(ras_falls == rs0 + 1, "R6 row miss reopens", 72'(ras_falls), 72'(rs0 + 1));
        host_op(1'b1, {12'hABC, 11'h000}, 72'h00_DEAD_BEEF_CAFE_F00D, 1'b0);
        host_op(1'b0, {12'hABC, 11'h000}, '0, 1'b0);

        rf0 = refresh_cnt;
        ak0 = acks;
        @(posedge clk); #1;
        refresh_req = 1'b1;
        @(posedge clk); #1;
        refresh_req = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(refresh_cnt == rf0 + 1, "R10 refresh issued", 72'(refresh_cnt), 72'(rf0 + 1));
        chk(acks == ak0, "R10 no ack for refresh", 72'(acks), 72'(ak0));

        rs0 = ras_falls;
        host_op(1'b0, {12'h005, 11'h003}, '0, 1'b0);
        chk(ras_falls == rs0 + 1, "R6 reopen after refresh", 72'(ras_falls), 72'(rs0 + 1));

        rs0 = ras_falls;
        rf0 = refresh_cnt;
        host_op(1'b0, {12'h005, 11'h7FF}, '0, 1'b1);
        chk(refresh_cnt == rf0 + 1, "R11 refresh serviced", 72'(refresh_cnt), 72'(rf0 + 1));
        chk(ras_falls == rs0 + 1, "R11 page closed by refresh", 72'(ras_falls), 72'(rs0 + 1));
        chk(last_ref_cyc < ack_cyc, "R11 refresh before access", 72'(last_ref_cyc), 72'(ack_cyc));

        host_op(1'b1, 23'h7FFFFF, 72'hFF_8000_0000_0000_0001, 1'b0);
        host_op(1'b0, 23'h7FFFFF, '0, 1'b0);
        host_op(1'b0, 23'h000000, '0, 1'b0);

        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(acks == ops, "R12 one ack per request", 72'(acks), 72'(ops));
        chk(exp_q.size() == 0, "R3 all reads returned", 72'(exp_q.size()), 72'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule